// File: doc/BRIEF.md
# Link Test Frame Generator and Bit Error Checker

This block supports bring-up and soak testing of a 120-bit-per-cycle optical link datapath. On the transmit side it produces one 120-bit test frame on each enabled cycle. The frame follows one of three selectable layouts. Each layout starts with a constant 4-bit header. The rest of the frame is either a fixed hex pattern, a set of frame counters, or a repeated 7-bit pseudo-random word.

On the receive side it compares each valid incoming frame against the fixed-pattern frame. It adds the number of mismatching bits to an error counter, which stops at its maximum value and can be cleared synchronously. A typical use loops the transmit frame back through the link, or straight into the receive input, and reads the counter after a test interval. Serialization and scrambling belong to neighbouring blocks.

Top module: `lnk_tpat_top`

## Requirements
- R1: Every generated frame carries 4'b0101 in bits 119:116. A frame is registered and appears on `tx_frame` one clock edge after the edge at which `gen_en` is sampled high.
- R2: With `pat_sel` = 2'd0, and also with the unused code 2'd3, bits 115:0 hold the 29 hex digits AAA BBBB AAAA BBBB AAAA BBBB AAAA BB, most significant digit first.
- R3: With `pat_sel` = 2'd1, bits 115:90 hold the low 26 bits of the frame count. Bits 89:60, 59:30 and 29:0 each hold the 30-bit frame count. The frame count is the number of frames generated since reset, starting at 0.
- R4: With `pat_sel` = 2'd2, bits 115:112 are zero and bits 111:0 hold sixteen copies of a 7-bit word. The word is 7'h01 after reset. Each following word is reached by seven steps of s <= {s[5:0], s[6]^s[5]}.
- R5: The frame count and the pseudo-random word advance on every generated frame, whatever pattern is selected. A change of `pat_sel` affects only the layout of the next frame.
- R6: While `gen_en` is low, `tx_frame` holds its value and neither the frame count nor the pseudo-random word advances.
- R7: After a synchronous active-low reset, `tx_frame` and `err_cnt` are zero.
- R8: At an edge where `rx_valid` is high and `err_clr` is low, `err_cnt` grows by the number of bit positions where `rx_frame` differs from the R1/R2 fixed frame. The fixed frame is the reference regardless of `pat_sel`.
- R9: At an edge where `rx_valid` and `err_clr` are both low, `err_cnt` does not change.
- R10: `err_cnt` saturates at 2^ERR_W-1 (ERR_W defaults to 32) and stays there until cleared.
- R11: `err_clr` high at an edge sets `err_cnt` to zero. It takes priority over a valid frame at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pat_sel | input | 2 | Pattern select: 0 fixed, 1 counters, 2 pseudo-random, 3 fixed |
| gen_en | input | 1 | Generate a frame at this edge |
| tx_frame | output | 120 | Generated test frame |
| rx_frame | input | 120 | Received frame to check |
| rx_valid | input | 1 | rx_frame is valid this cycle |
| err_clr | input | 1 | Clear the error counter |
| err_cnt | output | ERR_W | Saturating bit error count |

## Verification
The hardest situation to reach from the ports is the error counter at its ceiling. At 32 bits that needs millions of fully corrupted frames. The bench therefore builds the block with an 8-bit counter and feeds all-ones flip masks, so the counter crosses 255 on the third frame with a partial carry. A second hard case is checking against the fixed reference while the generator emits counter frames. The bench reaches it by freezing the generator on a counter frame and looping that frame back, then comparing with a popcount it computes itself.

// File: rtl/lnk_tpat_pkg.sv
// Package: shared constants, pattern codes and frame helpers for the
// link test frame generator and checker. Assumes a fixed 120-bit frame.
package lnk_tpat_pkg;

    localparam int FRAME_W   = 120;
    localparam int HDR_W     = 4;
    localparam logic [HDR_W-1:0] HDR_VAL = 4'b0101;
    localparam int PAYLOAD_W = FRAME_W - HDR_W;
    localparam int NIBBLES   = PAYLOAD_W / 4;
    localparam int CNT_W     = 30;
    localparam int CNT_SHORT_W = 26;
    localparam int CNT_REP   = 3;
    localparam int PRBS_W    = 7;
    localparam int PRBS_REP  = 16;
    localparam int PRBS_PAD  = PAYLOAD_W - PRBS_W * PRBS_REP;

    typedef enum logic [1:0] {
        PAT_FIXED = 2'd0,
        PAT_COUNT = 2'd1,
        PAT_PRBS  = 2'd2,
        PAT_SPARE = 2'd3
    } pat_e;

    // Builds the fixed frame: header then alternating A/B digit groups.
    function automatic logic [FRAME_W-1:0] fixed_frame();
        logic [PAYLOAD_W-1:0] p;
        p = '0;
        for (int i = 0; i < NIBBLES; i++) begin
            p[PAYLOAD_W-1-4*i -: 4] = ((((i + 1) / 4) % 2) == 0) ? 4'hA : 4'hB;
        end
        return {HDR_VAL, p};
    endfunction

    // Advances the x^7+x^6+1 sequence by one whole 7-bit word.
    function automatic logic [PRBS_W-1:0] prbs_word_step(input logic [PRBS_W-1:0] s_in);
        logic [PRBS_W-1:0] s;
        s = s_in;
        for (int k = 0; k < PRBS_W; k++) begin
            s = {s[PRBS_W-2:0], s[6] ^ s[5]};
        end
        return s;
    endfunction

endpackage

// File: rtl/lnk_tpat_gen.sv
// Frame generator: registers one 120-bit test frame per enabled cycle in
// the selected layout. The frame counter and pseudo-random word advance on
// every generated frame. Assumes pat_sel is stable around the clock edge.
module lnk_tpat_gen
    import lnk_tpat_pkg::*;
#(
    parameter logic [PRBS_W-1:0] PRBS_SEED = 7'h01
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         pat_sel,
    input  logic               gen_en,
    output logic [FRAME_W-1:0] tx_frame
);

    localparam logic [FRAME_W-1:0] FIXED = fixed_frame();

    logic [CNT_W-1:0]   cnt_q;
    logic [PRBS_W-1:0]  prbs_q;
    logic [FRAME_W-1:0] cnt_frame;
    logic [FRAME_W-1:0] prbs_frame;
    logic [FRAME_W-1:0] next_frame;

    // Counter layout: header, short counter field, then repeated full fields.
    assign cnt_frame[FRAME_W-1 -: HDR_W]        = HDR_VAL;
    assign cnt_frame[PAYLOAD_W-1 -: CNT_SHORT_W] = cnt_q[CNT_SHORT_W-1:0];
    for (genvar g = 0; g < CNT_REP; g++) begin : g_cnt_field
        assign cnt_frame[g*CNT_W +: CNT_W] = cnt_q;
    end

    // Pseudo-random layout: header, zero pad, repeated 7-bit word.
    assign prbs_frame[FRAME_W-1 -: HDR_W]   = HDR_VAL;
    assign prbs_frame[PAYLOAD_W-1 -: PRBS_PAD] = '0;
    for (genvar g = 0; g < PRBS_REP; g++) begin : g_prbs_field
        assign prbs_frame[g*PRBS_W +: PRBS_W] = prbs_q;
    end

    // Selects the layout of the next frame.
    always_comb begin
        unique case (pat_e'(pat_sel))
            PAT_COUNT: next_frame = cnt_frame;
            PAT_PRBS:  next_frame = prbs_frame;
            default:   next_frame = FIXED;
        endcase
    end

    // Registers the frame and advances the generator state when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_frame <= '0;
            cnt_q    <= '0;
            prbs_q   <= PRBS_SEED;
        end else if (gen_en) begin
            tx_frame <= next_frame;
            cnt_q    <= cnt_q + 1'b1;
            prbs_q   <= prbs_word_step(prbs_q);
        end
    end

    // R1
    hdr_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gen_en |=> tx_frame[FRAME_W-1 -: HDR_W] == HDR_VAL);

    // R6
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |=> $stable(tx_frame));

    // R6
    state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |=> $stable(cnt_q) && $stable(prbs_q));

    // R4
    prbs_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gen_en |=> prbs_q != '0);

endmodule

// File: rtl/lnk_tpat_popcnt.sv
// Population count: counts set bits of a wide vector in 8-bit segments
// and sums the partial counts. Purely combinational.
module lnk_tpat_popcnt #(
    parameter int IN_W  = 120,
    parameter int OUT_W = $clog2(IN_W + 1)
) (
    input  logic [IN_W-1:0]  vec,
    output logic [OUT_W-1:0] count
);

    localparam int SEG_W = 8;
    localparam int NSEG  = (IN_W + SEG_W - 1) / SEG_W;
    localparam int PAD_W = NSEG * SEG_W;

    logic [PAD_W-1:0] padded;
    logic [3:0]       seg_cnt [NSEG];

    assign padded = PAD_W'(vec);

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        // Counts the set bits of one segment.
        always_comb begin
            seg_cnt[s] = '0;
            for (int b = 0; b < SEG_W; b++) begin
                seg_cnt[s] = seg_cnt[s] + 4'(padded[s*SEG_W + b]);
            end
        end
    end

    // Sums the segment counts.
    always_comb begin
        count = '0;
        for (int s = 0; s < NSEG; s++) begin
            count = count + OUT_W'(seg_cnt[s]);
        end
    end

endmodule

// File: rtl/lnk_tpat_chk.sv
// Bit error checker: on each valid frame adds the number of bits that
// differ from the fixed reference frame to a saturating counter. A clear
// request wins over a valid frame. Assumes ERR_W is at least 7.
module lnk_tpat_chk
    import lnk_tpat_pkg::*;
#(
    parameter int ERR_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FRAME_W-1:0] rx_frame,
    input  logic               rx_valid,
    input  logic               err_clr,
    output logic [ERR_W-1:0]   err_cnt
);

    localparam logic [FRAME_W-1:0] FIXED = fixed_frame();
    localparam int PC_W  = $clog2(FRAME_W + 1);
    localparam int SUM_W = ERR_W + 1;
    localparam logic [ERR_W-1:0] ERR_MAX = '1;

    logic [PC_W-1:0]  mism;
    logic [SUM_W-1:0] sum;

    lnk_tpat_popcnt #(
        .IN_W  (FRAME_W),
        .OUT_W (PC_W)
    ) i_popcnt (
        .vec   (rx_frame ^ FIXED),
        .count (mism)
    );

    // Adds the mismatch count with one spare bit to catch the carry.
    assign sum = {1'b0, err_cnt} + SUM_W'(mism);

    // Updates the counter: clear first, then saturating accumulate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_cnt <= '0;
        end else if (err_clr) begin
            err_cnt <= '0;
        end else if (rx_valid) begin
            err_cnt <= sum[ERR_W] ? ERR_MAX : sum[ERR_W-1:0];
        end
    end

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid && !err_clr |=> $stable(err_cnt));

    // R11
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr |=> err_cnt == '0);

    // R10
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt == ERR_MAX && !err_clr |=> err_cnt == ERR_MAX);

    // R8
    no_decrease_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !err_clr |=> err_cnt >= $past(err_cnt));

endmodule

// File: rtl/lnk_tpat_top.sv
// Top: link test frame generator and bit error checker side by side.
// The two halves share only the clock and reset; looping the transmit
// frame back to the receive input is left to the surrounding logic.
module lnk_tpat_top
    import lnk_tpat_pkg::*;
#(
    parameter int ERR_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         pat_sel,
    input  logic               gen_en,
    output logic [119:0]       tx_frame,
    input  logic [119:0]       rx_frame,
    input  logic               rx_valid,
    input  logic               err_clr,
    output logic [ERR_W-1:0]   err_cnt
);

    lnk_tpat_gen #(
        .PRBS_SEED (7'h01)
    ) i_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .pat_sel  (pat_sel),
        .gen_en   (gen_en),
        .tx_frame (tx_frame)
    );

    lnk_tpat_chk #(
        .ERR_W (ERR_W)
    ) i_chk (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_frame (rx_frame),
        .rx_valid (rx_valid),
        .err_clr  (err_clr),
        .err_cnt  (err_cnt)
    );

endmodule

// File: tb/test_lnk_tpat_top.sv
// Directed bench: the generator output is looped into the checker through
// a bit-flip mask. Expected frames and counts come from the requirements.
module test_lnk_tpat_top;

    localparam int ERR_W = 8;
    localparam logic [ERR_W-1:0] EMAX = '1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       pat_sel = 2'd0;
    logic             gen_en = 1'b0;
    logic [119:0]     tx_frame;
    logic [119:0]     flip = '0;
    logic [119:0]     rx_frame;
    logic             rx_valid = 1'b0;
    logic             err_clr = 1'b0;
    logic [ERR_W-1:0] err_cnt;

    int n_chk  = 0;
    int n_fail = 0;
    int nfr    = 0;
    logic [6:0] pw = 7'h01;
    logic [119:0] exp_f;

    localparam logic [119:0] FIXED_F = {4'b0101, 116'hAAA_BBBB_AAAA_BBBB_AAAA_BBBB_AAAA_BB};

    assign rx_frame = tx_frame ^ flip;

    always #2 clk = ~clk;

    lnk_tpat_top #(.ERR_W(ERR_W)) i_lnk_tpat_top (
        .clk(clk), .rst_n(rst_n), .pat_sel(pat_sel), .gen_en(gen_en),
        .tx_frame(tx_frame), .rx_frame(rx_frame), .rx_valid(rx_valid),
        .err_clr(err_clr), .err_cnt(err_cnt)
    );

    function automatic logic [6:0] adv(input logic [6:0] s_in);
        logic [6:0] s = s_in;
        for (int k = 0; k < 7; k++) s = {s[5:0], s[6] ^ s[5]};
        return s;
    endfunction

    function automatic logic [119:0] model(input logic [1:0] sel, input int n, input logic [6:0] w);
        logic [29:0] c = 30'(n);
        case (sel)
            2'd1:    return {4'b0101, c[25:0], c, c, c};
            2'd2:    return {4'b0101, 4'h0, {16{w}}};
            default: return FIXED_F;
        endcase
    endfunction

    task automatic check(input string req, input logic [119:0] got, input logic [119:0] expv);
        n_chk++;
        if (got !== expv) begin
            n_fail++;
            $display("FAIL %s got %h exp %h", req, got, expv);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // One enabled frame with the given select; records the expected frame.
    task automatic gen_one(input logic [1:0] sel);
        pat_sel = sel;
        gen_en  = 1'b1;
        exp_f   = model(sel, nfr, pw);
        step();
        nfr++;
        pw = adv(pw);
        gen_en = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(); step();
        check("R7 tx", tx_frame, '0);
        check("R7 err", 120'(err_cnt), '0);
        rst_n = 1'b1;
        nfr = 0;
        pw  = 7'h01;
    endtask

    task automatic t_fixed();
        gen_one(2'd0);
        check("R2 fixed", tx_frame, exp_f);
        check("R1 header", 120'(tx_frame[119:116]), 120'(4'b0101));
        gen_one(2'd3);
        check("R2 spare code", tx_frame, FIXED_F);
    endtask

    task automatic t_count();
        for (int i = 0; i < 3; i++) begin
            gen_one(2'd1);
            check("R3 counter", tx_frame, exp_f);
        end
    endtask

    task automatic t_prbs();
        gen_one(2'd2);
        check("R5 word advanced across other patterns", tx_frame, exp_f);
        for (int i = 0; i < 3; i++) begin
            gen_one(2'd2);
            check("R4 prbs", tx_frame, exp_f);
        end
    endtask

    task automatic t_hold();
        logic [119:0] held = tx_frame;
        pat_sel = 2'd1;
        gen_en  = 1'b0;
        for (int i = 0; i < 3; i++) begin
            step();
            check("R6 hold", tx_frame, held);
        end
        gen_one(2'd1);
        check("R6 no advance while idle", tx_frame, exp_f);
    endtask

    task automatic t_chk_basic();
        gen_one(2'd0);
        err_clr = 1'b1; step(); err_clr = 1'b0;
        rx_valid = 1'b1;
        flip = '0; step(); step();
        check("R8 clean frames", 120'(err_cnt), 0);
        flip = 120'h1 << 7; step();
        check("R8 single flip", 120'(err_cnt), 1);
        flip = (120'h1 << 0) | (120'h1 << 40) | (120'h1 << 77) | (120'h1 << 116) | (120'h1 << 119);
        step();
        check("R8 five flips", 120'(err_cnt), 6);
        rx_valid = 1'b0;
        flip = '1; step(); step();
        check("R9 invalid ignored", 120'(err_cnt), 6);
        err_clr = 1'b1; step();
        check("R11 clear", 120'(err_cnt), 0);
        rx_valid = 1'b1; step();
        check("R11 clear beats valid", 120'(err_cnt), 0);
        err_clr = 1'b0; rx_valid = 1'b0; flip = '0;
    endtask

    task automatic t_chk_ref();
        int d;
        gen_one(2'd1);
        err_clr = 1'b1; step(); err_clr = 1'b0;
        d = $countones(exp_f ^ FIXED_F);
        if (d > 255) d = 255;
        rx_valid = 1'b1; step(); rx_valid = 1'b0;
        check("R8 reference is fixed frame", 120'(err_cnt), 120'(d));
    endtask

    task automatic t_sat();
        gen_one(2'd0);
        err_clr = 1'b1; step(); err_clr = 1'b0;
        flip = '1; rx_valid = 1'b1;
        step();
        check("R8 full flip", 120'(err_cnt), 120);
        step();
        check("R8 two full flips", 120'(err_cnt), 240);
        step();
        check("R10 saturate", 120'(err_cnt), 120'(EMAX));
        step();
        check("R10 stays saturated", 120'(err_cnt), 120'(EMAX));
        rx_valid = 1'b0; flip = '0;
        err_clr = 1'b1; step(); err_clr = 1'b0;
        check("R11 clear from max", 120'(err_cnt), 0);
    endtask

    initial begin
        #(200000 * 4);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired got running exp finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_fixed();
        t_count();
        t_prbs();
        t_hold();
        t_chk_basic();
        t_chk_ref();
        t_sat();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule